// File: doc/BRIEF.md
# Interconnect Test Pattern Sequencer

This block runs one sub-test of a board interconnect self-test from the side of a single chip. Every participating pin is bidirectional and has a pull-up. The block never drives two conflicting levels onto a net. Instead, it first charges every pin to 1. It then lets a chosen subset of pins drive 0, with all data bits held at 0. A short therefore only ever pulls a neighbour low.

The subset follows a counting code over pin indices. Step k enables every pin whose index has bit k set. A charging step is placed between every two such steps. The run ends with the complement of the last code, so that the lowest-index pin is also driven once.

In send mode the chip drives the codes itself and reads its own pins back. In receive mode it charges pins but otherwise keeps every output enable off, while another chip drives the codes. In both modes every code step is compared against the expected word. Mismatching pins are collected into a fail map, and the sampled words are folded into a signature that stays readable after the run. A one-cycle completion pulse marks the end of the sub-test.

Top module: `ict_pattern_seq`

## Requirements
- R1: After reset: `busy`=0, `done`=0, `pin_oe`=0, `pin_do`=0, `fail_map`=0, `pass`=1 and `signature`=0.
- R2: A `start` seen while idle starts a run of exactly 2·L+2 one-cycle steps, where L = clog2(SPAN_PINS). `busy` is high for those steps. In the cycle right after the last step, `busy` is 0 and `done` is high for exactly one cycle.
- R3: Step 0, and every even step before the last, is a charge step. In a charge step `pin_oe` and `pin_do` are all ones, in either mode.
- R4: Odd step 2k+1 (k = 0..L-1) is code step k. In send mode, `pin_do` is 0 and `pin_oe[i]` equals bit k of the index i.
- R5: The last step (2·L+1) is the complement step. In send mode, `pin_do` is 0 and `pin_oe[i]` equals the inverse of bit L-1 of i.
- R6: In receive mode the step order is the same, but `pin_oe` is all zeros in every code step and in the complement step.
- R7: In code step k the expected read-back of pin i is the inverse of bit k of i. In the complement step it is bit L-1 of i. Each pin whose `pin_di` value differs from this at the end of a compared step has its bit set in `fail_map`. `fail_map` is cleared at start, and `pass` is 1 exactly when `fail_map` is 0.
- R8: `signature` is cleared when a run starts. At the end of every code step and of the complement step it becomes `{sig[W-2:0],0} ^ (sig[W-1] ? SIG_POLY : 0) ^ pin_di`, with W = N_PINS. It does not change otherwise, and keeps its value after `done` until the next start.
- R9: While `busy`, `start` is ignored. `mode_rx` is sampled only when a run starts, so changing it during a run has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sub-test when idle |
| mode_rx | input | 1 | 0 = send, 1 = receive; sampled at start |
| pin_di | input | N_PINS | Values read back from the pins |
| pin_oe | output | N_PINS | Per-pin output enable |
| pin_do | output | N_PINS | Per-pin output data |
| busy | output | 1 | Sub-test in progress |
| done | output | 1 | One-cycle end-of-sub-test pulse |
| pass | output | 1 | No mismatch seen in the last sub-test |
| fail_map | output | N_PINS | Pins that mismatched in any compared step |
| signature | output | N_PINS | Compressed read-back words |

## Verification
Clean board nets in send mode establish the reference enable sequence, fail map and signature. Receive mode is tried twice. With a modelled external sender it must give the same signature as send mode. With no sender, every pin stays charged, which shows that the block itself never drives in code steps. A short between pins 1 and 2, a pin 0 stuck at 1 and a pin 5 stuck at 0 must each leave exactly their own fail-map bits and change the signature. The pin 0 case can only be caught by the complement step. During one run, `start` and `mode_rx` are toggled to show that neither disturbs a run in progress.

// File: rtl/ictseq_pkg.sv
package ictseq_pkg;
   typedef enum logic [1:0] {
      STEP_CHARGE = 2'd0,
      STEP_CODE   = 2'd1,
      STEP_COMPL  = 2'd2
   } step_kind_e;
endpackage

// File: rtl/ictseq_step_ctrl.sv
module ictseq_step_ctrl
   import ictseq_pkg::*;
#(
   parameter int N_CODES = 4,
   parameter int IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             mode_rx,
   output logic             busy,
   output logic             rx_q,
   output logic             launch,
   output logic             compare,
   output step_kind_e       kind,
   output logic [IDX_W-1:0] code_idx,
   output logic             done
);
   localparam int N_STEPS = 2 * N_CODES + 2;
   localparam int CNT_W   = $clog2(N_STEPS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_STEPS - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_m1;
   logic             last;

   assign launch = start && !busy;
   assign last   = (cnt == LAST);
   assign cnt_m1 = cnt - CNT_W'(1);

   always_comb begin
      if (cnt == '0)      kind = STEP_CHARGE;
      else if (last)      kind = STEP_COMPL;
      else if (cnt[0])    kind = STEP_CODE;
      else                kind = STEP_CHARGE;
   end

   assign code_idx = IDX_W'(cnt_m1 >> 1);
   assign compare  = busy && (kind != STEP_CHARGE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         rx_q <= 1'b0;
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            busy <= 1'b1;
            cnt  <= '0;
            rx_q <= mode_rx;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
               cnt  <= '0;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   // R2
   run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
   // R2
   step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (cnt == $past(cnt) + CNT_W'(1)));
   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2
   done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R9
   mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(rx_q));
endmodule

// File: rtl/ictseq_pattern_gen.sv
module ictseq_pattern_gen
   import ictseq_pkg::*;
#(
   parameter int N_PINS  = 16,
   parameter int N_CODES = 4,
   parameter int IDX_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              rx_q,
   input  step_kind_e        kind,
   input  logic [IDX_W-1:0]  code_idx,
   output logic [N_PINS-1:0] pin_oe,
   output logic [N_PINS-1:0] pin_do,
   output logic [N_PINS-1:0] exp_word
);
   logic charging;
   logic drive_ok;

   assign charging = busy && (kind == STEP_CHARGE);
   assign drive_ok = busy && !rx_q;

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      localparam logic [N_CODES-1:0] IDX = N_CODES'(i);
      logic code_bit;
      logic top_bit;
      assign code_bit = IDX[code_idx];
      assign top_bit  = IDX[N_CODES-1];
      always_comb begin
         case (kind)
            STEP_CODE:  begin pin_oe[i] = drive_ok && code_bit; exp_word[i] = !code_bit; end
            STEP_COMPL: begin pin_oe[i] = drive_ok && !top_bit; exp_word[i] = top_bit;   end
            default:    begin pin_oe[i] = charging;             exp_word[i] = 1'b1;      end
         endcase
         pin_do[i] = charging;
      end
   end

   // R3
   charge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      charging |-> (pin_oe == '1 && pin_do == '1));
   // R6
   rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rx_q && kind != STEP_CHARGE) |-> (pin_oe == '0));
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pin_oe == '0 && pin_do == '0));
   // R4
   code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind != STEP_CHARGE) |-> (pin_do == '0));
endmodule

// File: rtl/ictseq_resp_check.sv
module ictseq_resp_check #(
   parameter int          N_PINS   = 16,
   parameter logic [N_PINS-1:0] SIG_POLY = N_PINS'(16'h1021)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              compare,
   input  logic [N_PINS-1:0] pin_di,
   input  logic [N_PINS-1:0] exp_word,
   output logic [N_PINS-1:0] fail_map,
   output logic [N_PINS-1:0] signature
);
   logic [N_PINS-1:0] sig_next;
   logic [N_PINS-1:0] feedback;

   assign feedback = signature[N_PINS-1] ? SIG_POLY : '0;
   assign sig_next = {signature[N_PINS-2:0], 1'b0} ^ feedback ^ pin_di;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         fail_map  <= '0;
         signature <= '0;
      end else if (compare) begin
         fail_map  <= fail_map | (pin_di ^ exp_word);
         signature <= sig_next;
      end
   end

   // R7
   mismatch_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (compare && !clear && pin_di != exp_word) |=> (fail_map != '0));
   // R8
   sig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!compare && !clear) |=> $stable(signature));
   // R7
   map_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((fail_map & $past(fail_map)) == $past(fail_map)));
endmodule

// File: rtl/ict_pattern_seq.sv
module ict_pattern_seq
   import ictseq_pkg::*;
#(
   parameter int N_PINS    = 16,
   parameter int SPAN_PINS = 16,
   parameter logic [N_PINS-1:0] SIG_POLY = N_PINS'(16'h1021)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_rx,
   input  logic [N_PINS-1:0] pin_di,
   output logic [N_PINS-1:0] pin_oe,
   output logic [N_PINS-1:0] pin_do,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic [N_PINS-1:0] fail_map,
   output logic [N_PINS-1:0] signature
);
   localparam int N_CODES = $clog2(SPAN_PINS);
   localparam int IDX_W   = (N_CODES > 1) ? $clog2(N_CODES) : 1;

   if (N_PINS < 2) begin : g_bad_pins
      $error("N_PINS must be at least 2");
   end
   if (SPAN_PINS < N_PINS) begin : g_bad_span
      $error("SPAN_PINS must not be below N_PINS");
   end
   if (SIG_POLY[0] != 1'b1) begin : g_bad_poly
      $error("SIG_POLY needs its lowest bit set");
   end

   logic              rx_q;
   logic              launch;
   logic              compare;
   step_kind_e        kind;
   logic [IDX_W-1:0]  code_idx;
   logic [N_PINS-1:0] exp_word;

   ictseq_step_ctrl #(.N_CODES(N_CODES), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_rx(mode_rx),
      .busy(busy), .rx_q(rx_q), .launch(launch), .compare(compare),
      .kind(kind), .code_idx(code_idx), .done(done)
   );

   ictseq_pattern_gen #(.N_PINS(N_PINS), .N_CODES(N_CODES), .IDX_W(IDX_W)) u_pat (
      .clk(clk), .rst_n(rst_n), .busy(busy), .rx_q(rx_q), .kind(kind),
      .code_idx(code_idx), .pin_oe(pin_oe), .pin_do(pin_do), .exp_word(exp_word)
   );

   ictseq_resp_check #(.N_PINS(N_PINS), .SIG_POLY(SIG_POLY)) u_chk (
      .clk(clk), .rst_n(rst_n), .clear(launch), .compare(compare),
      .pin_di(pin_di), .exp_word(exp_word), .fail_map(fail_map), .signature(signature)
   );

   assign pass = (fail_map == '0);

   // R9
   start_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: tb/sim_ict_pattern_seq.sv
module sim_ict_pattern_seq;
   localparam int N = 16;
   localparam int L = 4;
   localparam int STEPS = 2 * L + 2;
   localparam logic [N-1:0] POLY = 16'h1021;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic mode_rx = 1'b0;
   logic [N-1:0] pad, pin_oe, pin_do, fail_map, signature;
   logic busy, done, pass;
   logic [N-1:0] held, ext_oe, sa0, sa1;
   logic sh_en, sh_t;
   int sh_a, sh_b;
   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [N-1:0] sig_clean;

   always #10 clk = ~clk;

   ict_pattern_seq #(.N_PINS(N), .SPAN_PINS(N), .SIG_POLY(POLY)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_rx(mode_rx), .pin_di(pad),
      .pin_oe(pin_oe), .pin_do(pin_do), .busy(busy), .done(done), .pass(pass),
      .fail_map(fail_map), .signature(signature)
   );

   // board model: pull-up keeps last level, external sender pulls low, faults
   always_comb begin
      pad = '0;
      sh_t = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (pin_oe[i])      pad[i] = pin_do[i];
         else if (ext_oe[i]) pad[i] = 1'b0;
         else                pad[i] = held[i];
      end
      if (sh_en) begin
         sh_t = pad[sh_a] & pad[sh_b];
         pad[sh_a] = sh_t;
         pad[sh_b] = sh_t;
      end
      pad = (pad & ~sa0) | sa1;
   end

   always @(posedge clk) begin
      if (!rst_n) held <= '1;
      else        held <= pad;
   end

   function automatic logic [N-1:0] code_mask(input int k);
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) m[i] = ((i >> k) & 1) == 1;
      return m;
   endfunction

   function automatic bit is_charge(input int s);
      return (s == 0) || ((s % 2 == 0) && s < STEPS - 1);
   endfunction

   function automatic logic [N-1:0] want_oe(input int s, input bit rx);
      if (is_charge(s)) return '1;
      if (rx) return '0;
      if (s == STEPS - 1) return ~code_mask(L - 1);
      return code_mask((s - 1) / 2);
   endfunction

   function automatic logic [N-1:0] want_cap(input int s);
      if (s == STEPS - 1) return code_mask(L - 1);
      return ~code_mask((s - 1) / 2);
   endfunction

   function automatic logic [N-1:0] fold(input logic [N-1:0] sig, input logic [N-1:0] w);
      return {sig[N-2:0], 1'b0} ^ (sig[N-1] ? POLY : '0) ^ w;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_faults();
      sa0 = '0; sa1 = '0; sh_en = 1'b0; sh_a = 0; sh_b = 1; ext_oe = '0;
   endtask

   // runs one sub-test; checks step outputs, run length and done pulse
   task automatic run_seq(input bit rx, input bit sender, input bit perturb);
      bit oe_ok = 1;
      bit do_ok = 1;
      bit busy_ok = 1;
      @(negedge clk);
      start = 1'b1; mode_rx = rx;
      @(negedge clk);
      start = 1'b0;
      for (int s = 0; s < STEPS; s++) begin
         ext_oe = (sender && !is_charge(s)) ? want_oe(s, 1'b0) : '0;
         if (perturb && s == 3) begin start = 1'b1; mode_rx = ~rx; end
         if (perturb && s == 4) begin start = 1'b0; mode_rx = rx; end
         #1;
         if (pin_oe !== want_oe(s, rx)) oe_ok = 0;
         if (pin_do !== (is_charge(s) ? '1 : '0)) do_ok = 0;
         if (busy !== 1'b1) busy_ok = 0;
         @(negedge clk);
      end
      ext_oe = '0;
      start = 1'b0;
      chk(oe_ok, rx ? "R6 enables per step" : "R4 R5 enables per step", {16'h0, pin_oe}, 32'h0);
      chk(do_ok, "R3 data per step", {16'h0, pin_do}, 32'h0);
      chk(busy_ok, "R2 busy through run", {31'h0, busy}, 32'h1);
      chk(done === 1'b1 && busy === 1'b0, "R2 done after last step", {30'h0, busy, done}, 32'h1);
   endtask

   task automatic after_done(input logic [N-1:0] exp_map);
      chk(fail_map === exp_map, "R7 fail map", {16'h0, fail_map}, {16'h0, exp_map});
      chk(pass === (exp_map == '0), "R7 pass flag", {31'h0, pass}, {31'h0, exp_map == '0});
      @(negedge clk);
      chk(done === 1'b0, "R2 done lasts one cycle", {31'h0, done}, 32'h0);
   endtask

   task automatic t_reset();
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done at reset", {30'h0, busy, done}, 32'h0);
      chk(pin_oe === '0 && pin_do === '0, "R1 pins idle", {pin_oe, pin_do}, 32'h0);
      chk(fail_map === '0 && pass === 1'b1, "R1 fail map clear", {15'h0, pass, fail_map}, 32'h10000);
      chk(signature === '0, "R1 signature clear", {16'h0, signature}, 32'h0);
   endtask

   task automatic t_send_clean();
      logic [N-1:0] hold_sig;
      clear_faults();
      run_seq(1'b0, 1'b0, 1'b1);   // R9 start and mode toggled mid-run
      chk(signature === sig_clean, "R8 clean signature", {16'h0, signature}, {16'h0, sig_clean});
      hold_sig = signature;
      after_done('0);
      repeat (3) @(negedge clk);
      chk(signature === hold_sig, "R8 signature held after done", {16'h0, signature}, {16'h0, hold_sig});
   endtask

   task automatic t_rx_sender();
      clear_faults();
      run_seq(1'b1, 1'b1, 1'b0);
      chk(signature === sig_clean, "R8 R6 receive signature", {16'h0, signature}, {16'h0, sig_clean});
      after_done('0);
   endtask

   task automatic t_rx_alone();
      clear_faults();
      run_seq(1'b1, 1'b0, 1'b0);
      after_done('1);   // R6 nothing drives low
   endtask

   task automatic t_short12();
      clear_faults();
      sh_en = 1'b1; sh_a = 1; sh_b = 2;
      run_seq(1'b0, 1'b0, 1'b0);
      chk(signature !== sig_clean, "R8 short changes signature", {16'h0, signature}, {16'h0, sig_clean});
      after_done(16'h0006);
   endtask

   task automatic t_stuck1_pin0();
      clear_faults();
      sa1 = 16'h0001;
      run_seq(1'b0, 1'b0, 1'b0);
      after_done(16'h0001);   // R5 only the complement step exposes it
   endtask

   task automatic t_stuck0_pin5();
      clear_faults();
      sa0 = 16'h0020;
      run_seq(1'b0, 1'b0, 1'b0);
      chk(signature !== sig_clean, "R8 stuck-at-0 changes signature", {16'h0, signature}, {16'h0, sig_clean});
      after_done(16'h0020);
   endtask

   initial begin
      clear_faults();
      sig_clean = '0;
      for (int s = 1; s < STEPS; s += 2) sig_clean = fold(sig_clean, want_cap(s));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_send_clean();
      t_rx_sender();
      t_rx_alone();
      t_short12();
      t_stuck1_pin0();
      t_stuck0_pin5();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog R2 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule